// File: doc/BRIEF.md
# Sleep Clock Source Selection, Division and Calibration

This block produces the low-rate timebase used for sleep timing and measures its period against the fast main clock. Two slow oscillators arrive as free-running level inputs: an internal source of about 100 kHz and an external 32 kHz crystal source. Each is brought into the main-clock domain through a two-flop synchronizer, and its rising edges are detected there. A 2-bit select code picks one source. A stop bit gates the chosen source and is active high, so its reset value of 0 leaves the oscillators running. A 5-bit divisor then thins the chosen edges into a single-cycle tick.

Software measures the period of the tick by pulsing a calibration start input. The block waits for the first tick after start. It then counts main-clock cycles, nominally at 20 MHz, until the sixteenth tick after that one. The 20-bit result is presented with a ready flag. The flag and the count hold until the next start. A start pulse during a measurement abandons that measurement and begins a new one. Control and status pins are plain levels and pulses. There is no streaming data interface, so there is no valid/ready handshake and no back-pressure.

Top module: `sleep_clock_cal`

## Requirements
- R1: After reset, `slp_tick` is 0, `cal_count` is 0 and `cal_ready` is 0.
- R2: With `src_sel` = 2'b10, ticks follow the rising edges of `osc_int_i`. With `src_sel` = 2'b01, they follow the rising edges of `osc_ext_i`.
- R3: With `src_sel` = 2'b00 or 2'b11, no tick is produced.
- R4: With `clk_stop` = 1, no tick is produced. With `clk_stop` = 0, the selected source runs.
- R5: With `div_val` = N in 1..31, there is one tick per N rising edges of the selected source, so the tick period is N source periods. `div_val` = 0 acts as divide-by-1.
- R6: After a start, `cal_count` gives the number of main-clock cycles from the first tick after start to the sixteenth tick after it. This equals 16 tick periods.
- R7: `cal_ready` rises on the cycle after the sixteenth tick. While no start occurs, `cal_ready` stays high and `cal_count` is unchanged.
- R8: A `cal_start` pulse clears `cal_ready` and `cal_count` one cycle later, including while a measurement is in progress. It then restarts the measurement.
- R9: When the count would pass all ones (2^CNT_W - 1), it holds at all ones.
- R10: `slp_tick` is high for one main-clock cycle per tick and is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_main | input | 1 | Main clock (nominally 20 MHz) |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_int_i | input | 1 | Internal ~100 kHz oscillator, asynchronous level |
| osc_ext_i | input | 1 | External 32 kHz oscillator, asynchronous level |
| src_sel | input | 2 | Source code: 10 internal, 01 external, others none |
| clk_stop | input | 1 | 1 stops the sleep clock, 0 runs it |
| div_val | input | 5 | Divisor; 0 means divide-by-1 |
| cal_start | input | 1 | One-cycle pulse that starts or restarts calibration |
| slp_tick | output | 1 | Single-cycle pulse per divided sleep-clock period |
| cal_count | output | 20 | Main-clock cycles over 16 tick periods |
| cal_ready | output | 1 | Count valid; held until the next start |

## Verification
A source rising edge reaches `slp_tick` three clock edges after the edge is sampled: two synchronizer stages plus the tick register. The bench therefore measures the spacing between consecutive ticks, so the latency cancels out of the tick periods it checks. The ready flag is checked low exactly one edge after a start pulse. A result is due on the cycle after the sixteenth tick. The bench's monitor compares it at the first rising edge of ready, against a value the driver queued from 16 × divisor × source period. Silence under a stopped or invalid source is judged on a tick-count window that opens a few cycles after the change, once ticks already in the pipeline have drained.

// File: rtl/slk_pkg.sv
package slk_pkg;
  localparam logic [1:0] SEL_INT = 2'b10;
  localparam logic [1:0] SEL_EXT = 2'b01;

  typedef enum logic [1:0] {
    CAL_IDLE = 2'b00,
    CAL_ARM  = 2'b01,
    CAL_RUN  = 2'b10,
    CAL_DONE = 2'b11
  } cal_state_t;
endpackage

// File: rtl/slk_edge_sync.sv
module slk_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_in};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~last_q;

  AST_RISE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise); // R10
endmodule

// File: rtl/slk_divider.sv
module slk_divider #(
  parameter int DIV_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             edge_in,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W:0]   limit;
  logic [DIV_W:0]   nxt;

  always_comb begin
    limit = (div_val == '0) ? {{DIV_W{1'b0}}, 1'b1} : {1'b0, div_val};
    nxt   = {1'b0, cnt_q} + {{DIV_W{1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else if (!run) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (edge_in) begin
        if (nxt >= limit) begin
          cnt_q <= '0;
          tick  <= 1'b1;
        end else begin
          cnt_q <= nxt[DIV_W-1:0];
        end
      end
    end
  end

  AST_IDLE_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !tick); // R3
  AST_TICK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R10
endmodule

// File: rtl/slk_calibrator.sv
module slk_calibrator
  import slk_pkg::*;
#(
  parameter int CNT_W = 20,
  parameter int WIN   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             tick,
  output logic [CNT_W-1:0] count,
  output logic             ready
);
  localparam int WIN_W = (WIN > 1) ? $clog2(WIN) : 1;
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN - 1);

  cal_state_t       state_q;
  logic [WIN_W-1:0] win_q;
  logic [CNT_W-1:0] cnt_inc;

  assign cnt_inc = (&count) ? count : count + {{(CNT_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CAL_IDLE;
      win_q   <= '0;
      count   <= '0;
      ready   <= 1'b0;
    end else if (start) begin
      state_q <= CAL_ARM;
      win_q   <= '0;
      count   <= '0;
      ready   <= 1'b0;
    end else begin
      case (state_q)
        CAL_ARM: begin
          if (tick) begin
            state_q <= CAL_RUN;
            win_q   <= '0;
          end
        end
        CAL_RUN: begin
          count <= cnt_inc;
          if (tick) begin
            if (win_q == WIN_LAST) begin
              state_q <= CAL_DONE;
              ready   <= 1'b1;
            end else begin
              win_q <= win_q + {{(WIN_W-1){1'b0}}, 1'b1};
            end
          end
        end
        default: ;
      endcase
    end
  end

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!ready && count == '0)); // R8
  AST_READY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !start) |=> (ready && $stable(count))); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    ((&count) && !start) |=> (&count)); // R9
  AST_READY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(tick)); // R7
endmodule

// File: rtl/sleep_clock_cal.sv
module sleep_clock_cal
  import slk_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DIV_W       = 5,
  parameter int CNT_W       = 20,
  parameter int CAL_WIN     = 16
) (
  input  logic             clk_main,
  input  logic             rst_n,
  input  logic             osc_int_i,
  input  logic             osc_ext_i,
  input  logic [1:0]       src_sel,
  input  logic             clk_stop,
  input  logic [DIV_W-1:0] div_val,
  input  logic             cal_start,
  output logic             slp_tick,
  output logic [CNT_W-1:0] cal_count,
  output logic             cal_ready
);
  localparam int N_SRC = 2;

  logic [N_SRC-1:0] src_raw;
  logic [N_SRC-1:0] src_rise;
  logic             sel_valid;
  logic             sel_rise;
  logic             run;

  assign src_raw = {osc_ext_i, osc_int_i};

  for (genvar g = 0; g < N_SRC; g++) begin : g_sync
    slk_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk_main),
      .rst_n    (rst_n),
      .async_in (src_raw[g]),
      .rise     (src_rise[g])
    );
  end

  always_comb begin
    case (src_sel)
      SEL_INT: begin sel_valid = 1'b1; sel_rise = src_rise[0]; end
      SEL_EXT: begin sel_valid = 1'b1; sel_rise = src_rise[1]; end
      default: begin sel_valid = 1'b0; sel_rise = 1'b0;        end
    endcase
  end

  assign run = sel_valid & ~clk_stop;

  slk_divider #(.DIV_W(DIV_W)) u_div (
    .clk     (clk_main),
    .rst_n   (rst_n),
    .run     (run),
    .edge_in (sel_rise),
    .div_val (div_val),
    .tick    (slp_tick)
  );

  slk_calibrator #(.CNT_W(CNT_W), .WIN(CAL_WIN)) u_cal (
    .clk   (clk_main),
    .rst_n (rst_n),
    .start (cal_start),
    .tick  (slp_tick),
    .count (cal_count),
    .ready (cal_ready)
  );

  AST_STOP_SILENT: assert property (@(posedge clk_main) disable iff (!rst_n)
    clk_stop |=> !slp_tick); // R4
  AST_BAD_SEL_SILENT: assert property (@(posedge clk_main) disable iff (!rst_n)
    (src_sel == 2'b00 || src_sel == 2'b11) |=> !slp_tick); // R3
endmodule

// File: tb/sleep_clock_cal_test.sv
module sleep_clock_cal_test;
  logic        clk_main = 1'b0;
  logic        rst_n = 1'b0;
  logic        osc_int_i = 1'b0;
  logic        osc_ext_i = 1'b0;
  logic [1:0]  src_sel = 2'b10;
  logic        clk_stop = 1'b0;
  logic [4:0]  div_val = 5'd1;
  logic        cal_start = 1'b0;
  logic        slp_tick;
  logic [19:0] cal_count;
  logic        cal_ready;
  logic        tick_s;
  logic [7:0]  count_s;
  logic        ready_s;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int tick_n = 0;
  bit done = 0;
  int exp_q[$];
  logic ready_prev = 1'b0;

  localparam int INT_HALF = 3;   // internal period 6 cycles
  localparam int EXT_HALF = 10;  // external period 20 cycles

  always #2.5 clk_main = ~clk_main;  // 200 MHz

  sleep_clock_cal uut (
    .clk_main, .rst_n, .osc_int_i, .osc_ext_i, .src_sel, .clk_stop,
    .div_val, .cal_start, .slp_tick, .cal_count, .cal_ready
  );

  sleep_clock_cal #(.CNT_W(8)) uut_small (
    .clk_main, .rst_n, .osc_int_i, .osc_ext_i, .src_sel, .clk_stop,
    .div_val, .cal_start, .slp_tick(tick_s), .cal_count(count_s),
    .cal_ready(ready_s)
  );

  initial forever begin
    repeat (INT_HALF) @(negedge clk_main);
    osc_int_i = ~osc_int_i;
  end

  initial forever begin
    repeat (EXT_HALF) @(negedge clk_main);
    osc_ext_i = ~osc_ext_i;
  end

  always @(posedge clk_main) cyc <= cyc + 1;
  always @(negedge clk_main) if (slp_tick) tick_n++;

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  always @(posedge clk_main) if (cyc == 150000) begin
    tests++; fails++;
    $display("FAIL watchdog expired act=%0d exp<150000", cyc);
    summary();
  end

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // Scoreboard monitor: compares each completed calibration.
  always @(negedge clk_main) begin
    if (cal_ready && !ready_prev) begin
      if (exp_q.size() == 0) check("R7 unexpected ready", 1, 0);
      else check("R6 cal count", int'(cal_count), exp_q.pop_front());
    end
    ready_prev = cal_ready;
  end

  task automatic wait_tick(output int t);
    do @(negedge clk_main); while (!slp_tick);
    t = cyc;
  endtask

  task automatic tick_period(output int p);
    int t0, t1, t2;
    wait_tick(t0);  // discard one to settle divider phase
    wait_tick(t1);
    wait_tick(t2);
    p = t2 - t1;
  endtask

  task automatic pulse_start();
    @(negedge clk_main) cal_start = 1'b1;
    @(negedge clk_main) cal_start = 1'b0;
  endtask

  task automatic run_cal(int expv);
    exp_q.push_back(expv);
    pulse_start();
    check("R8 ready low after start", int'(cal_ready), 0);
    while (!cal_ready) @(negedge clk_main);
    @(negedge clk_main);
  endtask

  task automatic silent_window(string req);
    repeat (6) @(negedge clk_main);
    tick_n = 0;
    repeat (200) @(negedge clk_main);
    check(req, tick_n, 0);
  endtask

  initial begin
    int p;
    int held;
    repeat (3) @(negedge clk_main);
    check("R1 reset tick", int'(slp_tick), 0);
    check("R1 reset count", int'(cal_count), 0);
    check("R1 reset ready", int'(cal_ready), 0);
    rst_n = 1'b1;

    tick_period(p); check("R2 internal period", p, 6);
    tick_n = 0;
    repeat (60) @(negedge clk_main);
    check("R10 pulses per 60 cycles", (tick_n >= 9 && tick_n <= 11) ? 1 : 0, 1);
    src_sel = 2'b01;
    tick_period(p); check("R2 external period", p, 20);

    src_sel = 2'b00; silent_window("R3 sel 00 silent");
    src_sel = 2'b11; silent_window("R3 sel 11 silent");
    src_sel = 2'b10; clk_stop = 1'b1; silent_window("R4 stopped silent");
    clk_stop = 1'b0;
    tick_period(p); check("R4 resumes", p, 6);

    div_val = 5'd5;  tick_period(p); check("R5 div 5", p, 30);
    div_val = 5'd0;  tick_period(p); check("R5 div 0", p, 6);
    div_val = 5'd31; tick_period(p); check("R5 div 31", p, 186);

    div_val = 5'd1; tick_period(p);
    run_cal(96);
    held = int'(cal_count);
    repeat (50) @(negedge clk_main);
    check("R7 ready held", int'(cal_ready), 1);
    check("R7 count held", int'(cal_count), held);

    div_val = 5'd3; tick_period(p);
    run_cal(288);

    pulse_start();
    repeat (40) @(negedge clk_main);
    check("R8 busy not ready", int'(cal_ready), 0);
    div_val = 5'd1;
    src_sel = 2'b01;
    repeat (60) @(negedge clk_main);
    run_cal(320);
    check("R9 small saturates", int'(count_s), 255);
    check("R9 small ready", int'(ready_s), 1);

    repeat (5) @(negedge clk_main);
    check("R6 queue drained", exp_q.size(), 0);
    summary();
  end
endmodule